// File: doc/BRIEF.md
# Full-Chip Erase Sequencer with Verify and Retry

This block sits on the host side of a byte-wide electrically erasable memory. It drives the memory bus (address, write data and its drive enable, chip select, write strobe, read strobe, and the enable of the high-voltage programming supply) and carries out a complete chip erase. An erase pulse is opened by two back-to-back erase command writes. It stays open for a programmable number of clocks and is closed by the first verify command write. Each location is then checked in ascending order, and every check has its own verify write followed by a read.

When a location reads back anything other than all ones, the sequencer issues another erase pulse. It then continues checking from that same location, not from the start of the array. It gives up after a configurable number of pulses. Once checking is over, it writes a read command to leave verify mode, drops the high-voltage enable and reports either success or failure. A single start input launches the run. The busy, done and fail outputs report its progress.

Every bus cycle lasts a fixed number of clocks. Pre-programming before erase and single-byte programming are handled elsewhere.

Top module: `chip_wipe_seq`

## Requirements
- R1: After reset, busy, done, fail and the high-voltage enable are 0, and chip select, write strobe and read strobe are all high.
- R2: Every erase pulse begins with two consecutive write cycles carrying 20H. A single 20H write is never followed by a write of any other value.
- R3: The rising write strobe of the verify write that closes a pulse comes exactly PULSE_CLKS + CYC_LEN + 1 clocks after the rising write strobe of the second 20H write.
- R4: Each location checked gets its own write of A0H with that location's address, followed by one read cycle at the same address.
- R5: A read of FFH moves checking to the next address. Any other value starts a new erase pulse, and checking then resumes at the location that failed.
- R6: When the highest address (all address bits 1) reads FFH, the sequencer writes 00H and then sets done.
- R7: If a location fails after MAX_PULSES pulses have been issued, no further pulse is issued. The sequencer writes 00H, sets fail and clears done.
- R8: The high-voltage enable is 1 exactly while busy is 1. It rises when start is accepted and falls when the result is posted.
- R9: A start asserted while busy has no effect on the run in progress. The pulse count, verify count and result are the same as for an undisturbed run.
- R10: A write cycle holds the write strobe low for CYC_LEN-1 clocks, and a read cycle holds the read strobe low for CYC_LEN clocks. Both happen with chip select low, and the two strobes are never low together.
- R11: Done and fail hold their values until the next start, which clears both on the clock edge at which busy rises. They are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a full erase; honoured only while idle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last run erased and verified the whole array |
| fail | output | 1 | Last run ran out of erase pulses |
| fl_addr | output | ADDR_W | Memory address |
| fl_wdata | output | 8 | Command byte driven during writes |
| fl_drive | output | 1 | Data bus drive enable (1 during write cycles) |
| fl_rdata | input | 8 | Data returned by the memory |
| fl_ce_n | output | 1 | Chip select, active low |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_oe_n | output | 1 | Read strobe, active low |
| fl_vpp_en | output | 1 | High-voltage supply enable |

## Verification
Busy and the high-voltage enable rise one clock after start is sampled. The bench therefore drives start on a falling edge and reads busy and done at the next falling edge. Bus results are observed at the falling edge that follows the strobe edge. A memory model in the bench catches each rising write strobe there and times the pulse gap by counting falling edges, which must equal PULSE_CLKS + CYC_LEN + 1. Done or fail is posted at the edge that ends the exit write. The bench polls for it and waits two more falling edges before comparing pulse, verify and read counts with the hand-worked values in its vector table.

// File: rtl/wipe_pkg.sv
// Shared constants and state encoding for the chip erase sequencer.
// Assumes a byte-wide memory whose command set uses the values below.
package wipe_pkg;
    localparam int DW = 8;

    localparam logic [DW-1:0] OP_ERASE  = 8'h20;
    localparam logic [DW-1:0] OP_VERIFY = 8'hA0;
    localparam logic [DW-1:0] OP_READ   = 8'h00;
    localparam logic [DW-1:0] ERASED    = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_CONFIRM,
        ST_PULSE,
        ST_VFY_CMD,
        ST_VFY_READ,
        ST_EXIT
    } wipe_state_e;
endpackage

// File: rtl/wipe_bus_engine.sv
// Runs one memory bus cycle of CYC_LEN clocks whenever go is seen while idle.
// Address, data and direction are captured at launch and held for the cycle.
// Write: write strobe low for the first CYC_LEN-1 clocks, high in the last.
// Read: read strobe low for all CYC_LEN clocks. last marks the final clock.
// Assumes CYC_LEN >= 2 and that go drops or changes meaning after last.
module wipe_bus_engine #(
    parameter int ADDR_W  = 17,
    parameter int DW      = 8,
    parameter int CYC_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DW-1:0]     data_in,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DW-1:0]     data_o,
    output logic              drive_o,
    output logic              ce_n,
    output logic              we_n,
    output logic              oe_n,
    output logic              last
);
    localparam int CW = (CYC_LEN > 1) ? $clog2(CYC_LEN) : 1;
    localparam logic [CW-1:0] LAST_TICK = CW'(CYC_LEN - 1);

    logic          active;
    logic          wr_q;
    logic [CW-1:0] tick;

    // Launch, step and retire a bus cycle; capture its operands at launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            wr_q   <= 1'b0;
            tick   <= '0;
            addr_o <= '0;
            data_o <= '0;
        end else if (active) begin
            if (tick == LAST_TICK) begin
                active <= 1'b0;
            end else begin
                tick <= tick + 1'b1;
            end
        end else if (go) begin
            active <= 1'b1;
            tick   <= '0;
            wr_q   <= wr;
            addr_o <= addr_in;
            data_o <= data_in;
        end
    end

    // Derive the strobes from the cycle position.
    always_comb begin
        last    = active && (tick == LAST_TICK);
        ce_n    = !active;
        we_n    = !(active && wr_q && (tick != LAST_TICK));
        oe_n    = !(active && !wr_q);
        drive_o = active && wr_q;
    end
endmodule

// File: rtl/wipe_pulse_timer.sv
// Counts the erase pulse width. While run is high the count advances, and
// expired rises in the run's PULSE_CLKS-th clock. Dropping run clears it.
// Assumes PULSE_CLKS >= 1.
module wipe_pulse_timer #(
    parameter int PULSE_CLKS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(PULSE_CLKS + 1);
    localparam logic [TW-1:0] END_CNT = TW'(PULSE_CLKS - 1);

    logic [TW-1:0] cnt;

    // Advance while the pulse is open, restart from zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Flag the final clock of the pulse.
    always_comb expired = run && (cnt == END_CNT);
endmodule

// File: rtl/wipe_progress.sv
// Holds the verify address and the number of erase pulses spent in a run.
// clear restarts both, addr_step moves to the next location and pulse_step
// records one more pulse. Assumes MAX_PULSES >= 1.
module wipe_progress #(
    parameter int ADDR_W     = 17,
    parameter int MAX_PULSES = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              addr_step,
    input  logic              pulse_step,
    output logic [ADDR_W-1:0] addr,
    output logic              addr_last,
    output logic              budget_spent
);
    localparam int PW = $clog2(MAX_PULSES + 1);
    localparam logic [PW-1:0] LIMIT = PW'(MAX_PULSES);

    logic [PW-1:0] pulses;

    // Track the verify address across pulses.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            addr <= '0;
        end else if (addr_step) begin
            addr <= addr + 1'b1;
        end
    end

    // Count erase pulses issued in this run.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pulses <= '0;
        end else if (pulse_step && !budget_spent) begin
            pulses <= pulses + 1'b1;
        end
    end

    // Report the end of the array and an exhausted budget.
    always_comb begin
        addr_last    = &addr;
        budget_spent = (pulses == LIMIT);
    end
endmodule

// File: rtl/chip_wipe_seq.sv
// Full-chip erase sequencer. On start it raises the high-voltage enable and
// then loops: a 20H/20H pulse, a timed wait, and A0H-plus-read checks that
// walk upward from the resume address. A failing location triggers another
// pulse unless the budget is spent. The run ends with a 00H write and a
// done or fail verdict. Assumes the memory answers reads within CYC_LEN clocks.
module chip_wipe_seq #(
    parameter int ADDR_W     = 17,
    parameter int CYC_LEN    = 4,
    parameter int PULSE_CLKS = 1000,
    parameter int MAX_PULSES = 1000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    output logic                      busy,
    output logic                      done,
    output logic                      fail,
    output logic [ADDR_W-1:0]         fl_addr,
    output logic [wipe_pkg::DW-1:0]   fl_wdata,
    output logic                      fl_drive,
    input  logic [wipe_pkg::DW-1:0]   fl_rdata,
    output logic                      fl_ce_n,
    output logic                      fl_we_n,
    output logic                      fl_oe_n,
    output logic                      fl_vpp_en
);
    import wipe_pkg::*;

    wipe_state_e       state;
    logic              verdict_bad;
    logic              bus_go;
    logic              bus_wr;
    logic [DW-1:0]     bus_cmd;
    logic              bus_last;
    logic              pulse_done;
    logic [ADDR_W-1:0] cur_addr;
    logic              at_last;
    logic              spent;
    logic              accept;
    logic              byte_ok;

    // Pick the bus operation that belongs to each state.
    always_comb begin
        bus_go  = 1'b0;
        bus_wr  = 1'b1;
        bus_cmd = OP_READ;
        case (state)
            ST_SETUP, ST_CONFIRM: begin bus_go = 1'b1; bus_cmd = OP_ERASE;  end
            ST_VFY_CMD:           begin bus_go = 1'b1; bus_cmd = OP_VERIFY; end
            ST_VFY_READ:          begin bus_go = 1'b1; bus_wr  = 1'b0;      end
            ST_EXIT:              begin bus_go = 1'b1; bus_cmd = OP_READ;   end
            default:              ;
        endcase
        accept  = (state == ST_IDLE) && start;
        byte_ok = (fl_rdata == ERASED);
        busy    = (state != ST_IDLE);
    end

    // Step the erase/verify sequence and post the verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            verdict_bad <= 1'b0;
            done        <= 1'b0;
            fail        <= 1'b0;
            fl_vpp_en   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state     <= ST_SETUP;
                    done      <= 1'b0;
                    fail      <= 1'b0;
                    fl_vpp_en <= 1'b1;
                end
                ST_SETUP:   if (bus_last)   state <= ST_CONFIRM;
                ST_CONFIRM: if (bus_last)   state <= ST_PULSE;
                ST_PULSE:   if (pulse_done) state <= ST_VFY_CMD;
                ST_VFY_CMD: if (bus_last)   state <= ST_VFY_READ;
                ST_VFY_READ: if (bus_last) begin
                    if (byte_ok) begin
                        if (at_last) begin
                            state       <= ST_EXIT;
                            verdict_bad <= 1'b0;
                        end else begin
                            state <= ST_VFY_CMD;
                        end
                    end else if (spent) begin
                        state       <= ST_EXIT;
                        verdict_bad <= 1'b1;
                    end else begin
                        state <= ST_SETUP;
                    end
                end
                ST_EXIT: if (bus_last) begin
                    state     <= ST_IDLE;
                    done      <= !verdict_bad;
                    fail      <= verdict_bad;
                    fl_vpp_en <= 1'b0;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    wipe_bus_engine #(
        .ADDR_W (ADDR_W),
        .DW     (DW),
        .CYC_LEN(CYC_LEN)
    ) u_bus (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (bus_go),
        .wr     (bus_wr),
        .addr_in(cur_addr),
        .data_in(bus_cmd),
        .addr_o (fl_addr),
        .data_o (fl_wdata),
        .drive_o(fl_drive),
        .ce_n   (fl_ce_n),
        .we_n   (fl_we_n),
        .oe_n   (fl_oe_n),
        .last   (bus_last)
    );

    wipe_pulse_timer #(
        .PULSE_CLKS(PULSE_CLKS)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state == ST_PULSE),
        .expired(pulse_done)
    );

    wipe_progress #(
        .ADDR_W    (ADDR_W),
        .MAX_PULSES(MAX_PULSES)
    ) u_prog (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (accept),
        .addr_step   ((state == ST_VFY_READ) && bus_last && byte_ok && !at_last),
        .pulse_step  ((state == ST_CONFIRM) && bus_last),
        .addr        (cur_addr),
        .addr_last   (at_last),
        .budget_spent(spent)
    );
endmodule

// File: rtl/wipe_seq_checker.sv
// Protocol and handshake properties for chip_wipe_seq, bound to every instance.
module wipe_seq_checker #(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              fail,
    input logic              vpp,
    input logic              ce_n,
    input logic              we_n,
    input logic              oe_n,
    input logic [ADDR_W-1:0] addr
);
    a_r8_vpp_follows_busy: assert property (@(posedge clk) disable iff (!rst_n)
        vpp == busy);

    a_r1_idle_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ce_n && we_n && oe_n));

    a_r10_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !oe_n));

    a_r10_strobe_under_select: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n || !oe_n) |-> !ce_n);

    a_r10_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && $past(!ce_n)) |-> $stable(addr));

    a_r11_verdict_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));

    a_r11_verdict_held: assert property (@(posedge clk) disable iff (!rst_n)
        ((done || fail) && !start && !busy) |=> ($stable(done) && $stable(fail)));

    a_r11_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done && !fail));
endmodule

bind chip_wipe_seq wipe_seq_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start),
    .busy (busy),
    .done (done),
    .fail (fail),
    .vpp  (fl_vpp_en),
    .ce_n (fl_ce_n),
    .we_n (fl_we_n),
    .oe_n (fl_oe_n),
    .addr (fl_addr)
);

// File: tb/chip_wipe_seq_tb.sv
module chip_wipe_seq_tb;
    localparam int AW  = 4;
    localparam int CL  = 4;
    localparam int PC  = 10;
    localparam int MP  = 3;
    localparam int NLOC = 1 << AW;
    localparam int GAP = PC + CL + 1;

    // a1, need1, a2, need2, expected pulses, expected done, expected A0 writes
    localparam int NVEC = 6;
    localparam int VEC [NVEC][7] = '{
        '{15, 1, 15, 1, 1, 1, 16},
        '{ 5, 2, 15, 1, 2, 1, 17},
        '{ 0, 3, 15, 1, 3, 1, 18},
        '{ 3, 2, 15, 3, 3, 1, 18},
        '{ 7, 4, 15, 1, 3, 0, 10},
        '{ 2, 2, 15, 2, 2, 1, 17}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          busy, done, fail;
    logic [AW-1:0] fl_addr;
    logic [7:0]    fl_wdata;
    logic          fl_drive;
    logic [7:0]    fl_rdata;
    logic          fl_ce_n, fl_we_n, fl_oe_n, fl_vpp_en;

    always #5 clk = ~clk;

    chip_wipe_seq #(
        .ADDR_W(AW), .CYC_LEN(CL), .PULSE_CLKS(PC), .MAX_PULSES(MP)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .fail(fail), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_drive(fl_drive), .fl_rdata(fl_rdata), .fl_ce_n(fl_ce_n),
        .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .fl_vpp_en(fl_vpp_en)
    );

    // Memory model: a location reads FFH once it has seen need[] pulses.
    int   need [NLOC];
    logic clr = 1'b0;
    int   lat, erases, a0s, reads, proto_bad, gap_bad, vpp_bad, last_wr;
    int   cyc, erase_cyc, we_run, oe_run;
    bit   pend, gap_armed;
    logic pwe, poe;

    assign fl_rdata = (erases >= need[lat]) ? 8'hFF : 8'h00;

    always @(negedge clk) begin
        if (clr) begin
            lat = 0; erases = 0; a0s = 0; reads = 0; proto_bad = 0;
            gap_bad = 0; vpp_bad = 0; last_wr = -1; pend = 0; gap_armed = 0;
            we_run = 0; oe_run = 0;
        end else begin
            if (!fl_we_n) we_run++;
            if (!fl_oe_n) oe_run++;
            if (!fl_we_n && !fl_oe_n) proto_bad++;
            if (busy != fl_vpp_en) vpp_bad++;
            if (pwe === 1'b0 && fl_we_n) begin
                if (we_run != CL - 1 || fl_ce_n || !fl_drive) proto_bad++;
                we_run = 0;
                if (fl_wdata == 8'h20) begin
                    if (pend) begin
                        erases++; pend = 0; erase_cyc = cyc; gap_armed = 1;
                    end else pend = 1;
                end else begin
                    if (pend) proto_bad++;
                    pend = 0;
                    if (fl_wdata == 8'hA0) begin
                        a0s++; lat = int'(fl_addr);
                        if (gap_armed && (cyc - erase_cyc) != GAP) gap_bad++;
                        gap_armed = 0;
                    end
                end
                last_wr = int'(fl_wdata);
            end
            if (poe === 1'b0 && fl_oe_n) begin
                if (oe_run != CL) proto_bad++;
                if (int'(fl_addr) != lat) proto_bad++;
                oe_run = 0;
                reads++;
            end
        end
        pwe = fl_we_n;
        poe = fl_oe_n;
        cyc++;
    end

    int checks = 0;
    int failures = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    // Load a need pattern, launch a run, optionally poke start mid-run.
    task automatic run_vec(input int v, input bit poke);
        for (int i = 0; i < NLOC; i++) need[i] = 1;
        need[VEC[v][2]] = VEC[v][3];
        need[VEC[v][0]] = VEC[v][1];
        model_clear();
        pulse_start();
        for (int t = 0; t < 20000 && !(done || fail); t++) begin
            if (poke && (t == 40 || t == 150)) start = 1'b1;
            else start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        repeat (2) @(negedge clk);
        chk("R5/R7 pulses", erases, VEC[v][4]);
        chk("R6/R7 done", int'(done), VEC[v][5]);
        chk("R7 fail", int'(fail), 1 - VEC[v][5]);
        chk("R5 verify writes", a0s, VEC[v][6]);
        chk("R4 reads per verify", reads, a0s);
        chk("R6 exit command", last_wr, 0);
        chk("R2/R10 bus protocol", proto_bad, 0);
        chk("R3 pulse gap", gap_bad, 0);
        chk("R8 vpp tracks busy", vpp_bad, 0);
        chk("R8 vpp released", int'(fl_vpp_en), 0);
    endtask

    task automatic main_seq();
        for (int i = 0; i < NLOC; i++) need[i] = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 fail", int'(fail), 0);
        chk("R1 vpp", int'(fl_vpp_en), 0);
        chk("R1 strobes", int'({fl_ce_n, fl_we_n, fl_oe_n}), 7);

        for (int v = 0; v < NVEC; v++) run_vec(v, 1'b0);

        // R9: starts while busy leave the run untouched.
        run_vec(1, 1'b1);

        // R11: verdict holds, then a new start clears it as busy rises.
        repeat (5) @(negedge clk);
        chk("R11 done held", int'(done), 1);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk("R11 busy on start", int'(busy), 1);
        chk("R11 done cleared", int'(done), 0);
        chk("R8 vpp on start", int'(fl_vpp_en), 1);
        for (int t = 0; t < 20000 && busy; t++) @(negedge clk);
        chk("R11 second run done", int'(done), 1);
    endtask

    initial begin
        fork
            main_seq();
            begin
                repeat (150000) @(posedge clk);
                failures++;
                $display("FAIL watchdog expired actual=running expected=finished");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule